// File: doc/BRIEF.md
# Two-Address Command/Data Interrupt Controller

A programmable interrupt controller that the processor reaches through just two byte-wide locations. Writing the command location latches an 8-bit command. Its top three bits choose an operation and its low five bits choose an 8-line bank. Every later access to the data location is steered by that latched command. It can fetch the number of the interrupt being serviced, or read and write one bank of the enable or trigger-mode registers. Writing the reserved command 0xFF retires the interrupt currently being reported.

Each input line is captured into a pending bit. A line in edge mode sets its bit only on a low-to-high change against a one-cycle shadow copy. A line in level mode sets its bit in every cycle it is high. The lowest-numbered line that is both pending and enabled is the current interrupt, and the request output to the processor is high whenever one exists. The number of lines is a parameter that must be a multiple of 8 and no more than 256.

Top module: `cmdport_pic`

## Requirements
- R1: After reset the latched command reads 0x00, every enable and mode bank reads 0x00, and `irq_o` is low.
- R2: A write with `addr_i`=0 latches `wdata_i` as the command. A read with `addr_i`=0 returns the latched command, which holds until the next command write.
- R3: With command 0x20+b, data-port reads and writes reach enable bank b (lines 8b..8b+7, bit k = line 8b+k). With command 0x40+b they reach mode bank b (1 = level, 0 = edge). A write touches only the selected bank.
- R4: An edge-mode line sets its pending bit only on a rise. A line held high after end-of-interrupt does not set it again.
- R5: A level-mode line keeps its pending bit set while high. After end-of-interrupt it stays set if the line is still high.
- R6: `irq_o` is high exactly when some line is pending and enabled. Reading data under commands 0x00..0x1F returns the lowest such line number (0x00 when none).
- R7: A pending line that is disabled does not raise `irq_o`, but stays pending and becomes current once it is enabled.
- R8: Writing 0xFF to the command location clears only the pending bit of the current interrupt, and the next-lowest pending enabled line becomes current.
- R9: Commands 0x60..0xFE, and enable or mode commands whose bank index is at or above N_LINES/8, read 0x00 on the data port and ignore data writes.
- R10: A data write under commands 0x00..0x1F changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 = command location, 1 = data location |
| we_i | input | 1 | Write strobe for the addressed location |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed location (combinational) |
| irq_lines_i | input | N_LINES | Interrupt source lines, active high |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupt latched command shows on the very next read of either location: the command readback, or a data read steered to the wrong bank. A wrong enable or mode bit shows in bank readback, or as an `irq_o` change one cycle after a line moves. A stuck or lost pending bit shows up as an interrupt number or a request level that is off within one cycle of the end-of-interrupt write that should have moved it. The checks therefore follow every command write, line change and retirement with an immediate port read.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam logic [2:0] OP_IRQ  = 3'd0;
  localparam logic [2:0] OP_EN   = 3'd1;
  localparam logic [2:0] OP_MODE = 3'd2;
  localparam logic [7:0] CMD_EOI = 8'hFF;

  typedef struct packed {
    logic [2:0] op;
    logic [4:0] bank;
  } cmd_t;
endpackage

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
  import pic_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_i,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  output cmd_t          cmd_o,
  output logic          eoi_o,
  output logic          bank_ok_o,
  output logic [NB-1:0] en_we_o,
  output logic [NB-1:0] mode_we_o
);
  localparam logic [5:0] NB_W = 6'(NB);

  cmd_t cmd_q;
  logic cmd_wr, data_wr;

  assign cmd_wr  = we_i && !addr_i;
  assign data_wr = we_i && addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (cmd_wr) cmd_q <= cmd_t'(wdata_i);
  end

  assign cmd_o     = cmd_q;
  assign eoi_o     = cmd_wr && (wdata_i == CMD_EOI);
  assign bank_ok_o = {1'b0, cmd_q.bank} < NB_W;

  // one write enable per bank; data bus is shared
  for (genvar b = 0; b < NB; b++) begin : g_we
    assign en_we_o[b]   = data_wr && (cmd_q.op == OP_EN)   && (cmd_q.bank == 5'(b));
    assign mode_we_o[b] = data_wr && (cmd_q.op == OP_MODE) && (cmd_q.bank == 5'(b));
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs #(
  parameter int NB = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NB-1:0]       we_i,
  input  logic [7:0]          wdata_i,
  output logic [NB-1:0][7:0]  q_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[b] <= '0;
      else if (we_i[b])  q_o[b] <= wdata_i;
    end
  end
endmodule

// File: rtl/pic_pend.sv
module pic_pend #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  lines_i,
  input  logic [N-1:0]  level_i,
  input  logic          clr_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  shadow_o
);
  logic [N-1:0] clr_vec, set_vec;

  always_comb begin
    clr_vec = '0;
    if (clr_i) clr_vec[clr_idx_i] = 1'b1;
  end

  // edge: rise against shadow; level: high now. Set beats clear.
  assign set_vec = (lines_i & ~shadow_o & ~level_i) | (lines_i & level_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
      pend_o   <= '0;
    end else begin
      shadow_o <= lines_i;
      pend_o   <= (pend_o & ~clr_vec) | set_vec;
    end
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cmdport_pic.sv
module cmdport_pic
  import pic_pkg::*;
#(
  parameter int N_LINES = 32  // multiple of 8, at most 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               addr_i,
  input  logic               we_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [N_LINES-1:0] irq_lines_i,
  output logic               irq_o
);
  localparam int NB  = N_LINES / 8;
  localparam int IW  = $clog2(N_LINES);
  localparam int BIW = (NB > 1) ? $clog2(NB) : 1;

  cmd_t               cmd_q;
  logic               eoi, bank_ok;
  logic [NB-1:0]      en_we, mode_we;
  logic [NB-1:0][7:0] en_banks, mode_banks;
  logic [N_LINES-1:0] en_flat, mode_flat, pend, shadow;
  logic               irq_valid;
  logic [IW-1:0]      irq_id;
  logic [BIW-1:0]     bsel;
  logic [7:0]         bank_rd;

  pic_cmd_dec #(.NB(NB)) u_dec (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .cmd_o(cmd_q), .eoi_o(eoi), .bank_ok_o(bank_ok),
    .en_we_o(en_we), .mode_we_o(mode_we)
  );

  pic_regs #(.NB(NB)) u_en (
    .clk_i, .rst_ni, .we_i(en_we), .wdata_i, .q_o(en_banks)
  );

  pic_regs #(.NB(NB)) u_mode (
    .clk_i, .rst_ni, .we_i(mode_we), .wdata_i, .q_o(mode_banks)
  );

  assign en_flat   = en_banks;
  assign mode_flat = mode_banks;

  pic_pend #(.N(N_LINES), .IW(IW)) u_pend (
    .clk_i, .rst_ni, .lines_i(irq_lines_i), .level_i(mode_flat),
    .clr_i(eoi && irq_valid), .clr_idx_i(irq_id),
    .pend_o(pend), .shadow_o(shadow)
  );

  pic_prio #(.N(N_LINES), .IW(IW)) u_prio (
    .req_i(pend & en_flat), .valid_o(irq_valid), .idx_o(irq_id)
  );

  assign irq_o = irq_valid;
  assign bsel  = BIW'(cmd_q.bank);

  always_comb begin
    bank_rd = 8'h00;
    if (bank_ok) begin
      if (cmd_q.op == OP_EN)   bank_rd = en_banks[bsel];
      if (cmd_q.op == OP_MODE) bank_rd = mode_banks[bsel];
    end
  end

  always_comb begin
    if (!addr_i)                  rdata_o = cmd_q;
    else if (cmd_q.op == OP_IRQ)  rdata_o = irq_valid ? 8'(irq_id) : 8'h00;
    else                          rdata_o = bank_rd;
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N_LINES = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       addr_i,
  input logic                       we_i,
  input logic [7:0]                 wdata_i,
  input logic [N_LINES-1:0]         irq_lines_i,
  input logic                       irq_o,
  input logic [7:0]                 cmd_q,
  input logic [N_LINES-1:0]         en_flat,
  input logic [N_LINES-1:0]         mode_flat,
  input logic [N_LINES-1:0]         pend,
  input logic [N_LINES-1:0]         shadow,
  input logic [$clog2(N_LINES)-1:0] irq_id,
  input logic                       eoi
);
  localparam int NB = N_LINES / 8;

  logic [N_LINES-1:0] low_mask;
  logic               bad_cmd;

  assign low_mask = (N_LINES'(1) << irq_id) - N_LINES'(1);
  assign bad_cmd  = (cmd_q[7:5] > 3'd2) ||
                    ((cmd_q[7:5] != 3'd0) && (int'(cmd_q[4:0]) >= NB));

  p_cmd_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i) |=> cmd_q == $past(wdata_i));

  p_cmd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !addr_i) |=> $stable(cmd_q));

  p_edge_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(mode_flat)) &
              ~($past(irq_lines_i) & ~$past(shadow))) == '0);

  p_level_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(irq_lines_i) & $past(mode_flat)) & ~pend) == '0);

  p_irq_any_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(pend & en_flat)));

  p_lowest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend[irq_id] && en_flat[irq_id] && ((pend & en_flat & low_mask) == '0)));

  p_eoi_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && irq_o && !irq_lines_i[irq_id]) |=> !pend[$past(irq_id)]);

  p_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i && bad_cmd) |=> ($stable(en_flat) && $stable(mode_flat)));

  p_irq_ro_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i && cmd_q[7:5] == 3'd0) |=> ($stable(en_flat) && $stable(mode_flat)));
endmodule

bind cmdport_pic pic_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .irq_lines_i, .irq_o,
  .cmd_q(cmd_q), .en_flat(en_flat), .mode_flat(mode_flat), .pend(pend),
  .shadow(shadow), .irq_id(irq_id), .eoi(eoi)
);

// File: tb/cmdport_pic_tb.sv
`timescale 1ns/1ps
module cmdport_pic_tb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         addr = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [N-1:0] lines = '0;
  logic         irq;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  smp    = 1'b0;

  logic [7:0] q_exp[$];
  string      q_req[$];
  bit         q_irq[$];

  always #4 clk = ~clk;

  cmdport_pic #(.N_LINES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_lines_i(lines), .irq_o(irq)
  );

  // monitor: pops one expected item per sample strobe
  always @(negedge clk) begin
    if (smp && q_exp.size() > 0) begin
      logic [7:0] e, a;
      string r;
      bit k;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      k = q_irq.pop_front();
      a = k ? {7'b0, irq} : rdata;
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s %s actual=%h expected=%h", r, k ? "irq_o" : "rdata", a, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; we = 1'b1; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic chk_rd(input logic a, input logic [7:0] e, input string r);
    addr = a;
    q_exp.push_back(e); q_req.push_back(r); q_irq.push_back(1'b0);
    smp = 1'b1;
    tick();
    smp = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string r);
    q_exp.push_back({7'b0, e}); q_req.push_back(r); q_irq.push_back(1'b1);
    smp = 1'b1;
    tick();
    smp = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    chk_rd(1'b0, 8'h00, "R1");
    chk_irq(1'b0, "R1");
    wr(1'b0, 8'h20); chk_rd(1'b1, 8'h00, "R1");
    wr(1'b0, 8'h43); chk_rd(1'b1, 8'h00, "R1");

    // R2 / R3 command latch and bank access
    wr(1'b0, 8'h21); chk_rd(1'b0, 8'h21, "R2");
    wr(1'b1, 8'hA5); chk_rd(1'b1, 8'hA5, "R3");
    chk_rd(1'b0, 8'h21, "R2");
    wr(1'b0, 8'h20); chk_rd(1'b1, 8'h00, "R3");
    wr(1'b0, 8'h41); wr(1'b1, 8'h3C); chk_rd(1'b1, 8'h3C, "R3");
    wr(1'b0, 8'h21); chk_rd(1'b1, 8'hA5, "R3");

    // R9 unused codes and out-of-range banks
    wr(1'b0, 8'h24); wr(1'b1, 8'h77); chk_rd(1'b1, 8'h00, "R9");
    wr(1'b0, 8'h60); wr(1'b1, 8'h55); chk_rd(1'b1, 8'h00, "R9");
    wr(1'b0, 8'hE5); chk_rd(1'b1, 8'h00, "R9");
    wr(1'b0, 8'h21); chk_rd(1'b1, 8'hA5, "R9");
    wr(1'b0, 8'h41); chk_rd(1'b1, 8'h3C, "R9");

    // R10 IRQ read is read-only
    wr(1'b0, 8'h00); wr(1'b1, 8'h12); chk_rd(1'b1, 8'h00, "R10");
    chk_irq(1'b0, "R10");
    wr(1'b0, 8'h20); chk_rd(1'b1, 8'h00, "R10");

    // enable bank 0
    wr(1'b1, 8'hFF);

    // R4 edge: line 3
    lines = 32'h8; tick();
    chk_irq(1'b1, "R4");
    wr(1'b0, 8'h00); chk_rd(1'b1, 8'h03, "R6");
    wr(1'b0, 8'hFF); chk_irq(1'b0, "R4");
    tick(); chk_irq(1'b0, "R4");
    lines = '0; tick();

    // R5 level: line 2
    wr(1'b0, 8'h40); wr(1'b1, 8'h04);
    lines = 32'h4; tick();
    chk_irq(1'b1, "R5");
    wr(1'b0, 8'hFF); chk_irq(1'b1, "R5");
    wr(1'b0, 8'h00); chk_rd(1'b1, 8'h02, "R5");
    lines = '0; tick();
    wr(1'b0, 8'hFF); chk_irq(1'b0, "R5");

    // R6 / R7 / R8 priority and retirement: lines 1, 5, 9 (9 disabled)
    lines = (32'h1 << 1) | (32'h1 << 5) | (32'h1 << 9); tick();
    wr(1'b0, 8'h00); chk_rd(1'b1, 8'h01, "R6");
    wr(1'b0, 8'hFF); wr(1'b0, 8'h00); chk_rd(1'b1, 8'h05, "R8");
    wr(1'b0, 8'hFF); chk_irq(1'b0, "R7");
    wr(1'b0, 8'h21); wr(1'b1, 8'h02); chk_irq(1'b1, "R7");
    wr(1'b0, 8'h00); chk_rd(1'b1, 8'h09, "R7");
    wr(1'b0, 8'hFF); chk_irq(1'b0, "R8");
    wr(1'b0, 8'h00); chk_rd(1'b1, 8'h00, "R6");

    tick();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule